// File: doc/BRIEF.md
# Serial Frame Encoder and Checker

This block takes one character and packs it into the bit sequence a serial line would carry: data bits starting with the least significant, an optional parity bit, and one or two stop bits, all chosen by a transmit line-control byte. The same packed frame is then decoded under a second, independent receive line-control byte. Decoding returns the recovered character, a parity-error flag and a framing-error flag. The two settings may disagree. This lets a test environment model what a receiver set up with different word length, parity or stop-bit choices would report.

The encoder and decoder are pure combinational logic. A start strobe captures the frame, its bit count and the decoded result into output registers. A valid flag marks the cycle after the strobe. Baud timing, line driving and oversampling are outside the block.

Top module: `serial_frame_codec`

## Requirements
- R1: Both line-control bytes use this layout: bits [1:0] pick the word length as 5 plus their value; bit 2 selects a second stop bit; bit 3 enables parity; bit 4 selects even parity (0 = odd); bit 5 forces stick parity. On transmit, data bits above the word length are cleared before packing, and data bit i lands in frame bit i.
- R2: With transmit parity enabled, the parity bit is placed right after the data. It is 1 when stick is set, whatever bit 4 holds. Otherwise it is the XOR of the kept data bits for even parity and the inverse of that XOR for odd parity.
- R3: A stop bit of 1 follows the data and any parity bit. A second 1 follows when transmit bit 2 is set. The frame length output equals word length plus parity plus stop bits, in the range 6 to 11, and every frame bit at or above that length is 0.
- R4: Result bits [7:0] hold the low frame bits up to the receive word length, and the bits above that length are 0.
- R5: With receive parity and stick enabled, the parity error is 1 exactly when frame bit N is 0, where N is the receive word length.
- R6: With receive parity enabled and stick clear, X is the XOR of frame bits 0 through N. For even parity the error equals X. For odd parity the error equals the inverse of X.
- R7: The parity error is 0 whenever receive bit 3 is clear.
- R8: The framing error is the inverse of the frame bit at position S, where S is N plus 1 if receive parity is on and N otherwise. When receive bit 2 is set, the inverse of bit S+1 is ORed in.
- R9: The result word has the full receive line-control byte in bits [15:8], the parity error in bit 16 and the framing error in bit 17.
- R10: Frame, length and result are loaded on the clock edge where start is high and held otherwise. The valid output is high for exactly the cycle after start. Synchronous reset clears all outputs to 0.
- R11: Bits 7:6 of the transmit line-control byte have no effect on the frame or its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Capture strobe |
| data_i | input | 8 | Character to encode |
| tx_lcr_i | input | 8 | Transmit line-control byte |
| rx_lcr_i | input | 8 | Receive line-control byte |
| frame_o | output | 12 | Packed frame, first bit at bit 0 |
| frame_len_o | output | 4 | Number of bits in the frame |
| result_o | output | 18 | Decoded data, receive settings, parity and framing errors |
| valid_o | output | 1 | Result valid, one cycle after start |

## Verification
Random characters are sent with random transmit settings. Half the time the receive settings match the transmit side apart from the ignored top bits, and any error flag there points to a broken encoder or decoder. The other half uses unrelated receive settings, which exercises misaligned parity and stop positions. Directed cases pair each parity flavour against its opposite and against stick parity, and pair one stop bit against two, so that each error source is driven on its own. A further directed case shows that transmit bits 7:6 have no effect. Checks of hold and of the single-cycle valid pulse separate a missing load enable from a correct register stage.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

    localparam int unsigned MAX_DATA_BITS = 8;
    localparam int unsigned MIN_DATA_BITS = 5;
    localparam int unsigned LCR_BITS      = 8;
    localparam int unsigned FRAME_BITS    = MAX_DATA_BITS + 4;
    localparam int unsigned LEN_BITS      = $clog2(FRAME_BITS + 1);
    localparam int unsigned RESULT_BITS   = MAX_DATA_BITS + LCR_BITS + 2;

    typedef struct packed {
        logic [1:0] spare;
        logic       stick;
        logic       even;
        logic       par_en;
        logic       two_stop;
        logic [1:0] wsel;
    } line_ctrl_t;

    typedef logic [FRAME_BITS-1:0]    frame_t;
    typedef logic [LEN_BITS-1:0]      len_t;
    typedef logic [MAX_DATA_BITS-1:0] char_t;

    typedef struct packed {
        logic                frame_err;
        logic                par_err;
        logic [LCR_BITS-1:0] rx_ctrl;
        char_t               data;
    } result_t;

    // Number of data bits selected by the word-length field.
    function automatic len_t word_len(input logic [1:0] wsel);
        return len_t'(MIN_DATA_BITS) + len_t'(wsel);
    endfunction

    // Mask with the lowest n bits set.
    function automatic char_t low_mask(input len_t n);
        char_t m;
        m = '0;
        for (int i = 0; i < int'(MAX_DATA_BITS); i++) begin
            if (len_t'(i) < n) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/sfc_frame_builder.sv
module sfc_frame_builder
    import sfc_pkg::*;
(
    input  char_t      data_i,
    input  line_ctrl_t ctrl_i,
    output frame_t     frame_o,
    output len_t       len_o
);

    always_comb begin
        len_t  n;
        len_t  pos;
        char_t kept;
        logic  parity;

        n       = word_len(ctrl_i.wsel);
        kept    = data_i & low_mask(n);
        parity  = ^kept;
        frame_o = '0;
        frame_o[MAX_DATA_BITS-1:0] = kept;
        pos     = n;
        if (ctrl_i.par_en) begin
            frame_o[pos] = ctrl_i.stick ? 1'b1 : (ctrl_i.even ? parity : ~parity);
            pos = pos + len_t'(1);
        end
        frame_o[pos] = 1'b1;
        pos = pos + len_t'(1);
        if (ctrl_i.two_stop) begin
            frame_o[pos] = 1'b1;
            pos = pos + len_t'(1);
        end
        len_o = pos;
    end

endmodule

// File: rtl/sfc_frame_checker.sv
module sfc_frame_checker
    import sfc_pkg::*;
(
    input  frame_t     frame_i,
    input  line_ctrl_t ctrl_i,
    output result_t    result_o
);

    always_comb begin
        len_t n;
        len_t stop_a;
        len_t stop_b;
        logic acc;

        n   = word_len(ctrl_i.wsel);
        acc = 1'b0;
        for (int i = 0; i <= int'(MAX_DATA_BITS); i++) begin
            if (len_t'(i) <= n) acc = acc ^ frame_i[i];
        end
        stop_a = n + len_t'(ctrl_i.par_en);
        stop_b = stop_a + len_t'(1);

        result_o.data    = frame_i[MAX_DATA_BITS-1:0] & low_mask(n);
        result_o.rx_ctrl = ctrl_i;
        if (!ctrl_i.par_en)
            result_o.par_err = 1'b0;
        else if (ctrl_i.stick)
            result_o.par_err = ~frame_i[n];
        else
            result_o.par_err = ctrl_i.even ? acc : ~acc;
        result_o.frame_err = ~frame_i[stop_a] | (ctrl_i.two_stop & ~frame_i[stop_b]);
    end

endmodule

// File: rtl/sfc_out_stage.sv
module sfc_out_stage
    import sfc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    load_i,
    input  frame_t  frame_i,
    input  len_t    len_i,
    input  result_t result_i,
    output frame_t  frame_o,
    output len_t    len_o,
    output result_t result_o,
    output logic    valid_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_o  <= '0;
            len_o    <= '0;
            result_o <= '0;
            valid_o  <= 1'b0;
        end else begin
            valid_o <= load_i;
            if (load_i) begin
                frame_o  <= frame_i;
                len_o    <= len_i;
                result_o <= result_i;
            end
        end
    end

endmodule

// File: rtl/serial_frame_codec.sv
module serial_frame_codec
    import sfc_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start_i,
    input  logic [MAX_DATA_BITS-1:0] data_i,
    input  logic [LCR_BITS-1:0]    tx_lcr_i,
    input  logic [LCR_BITS-1:0]    rx_lcr_i,
    output logic [FRAME_BITS-1:0]  frame_o,
    output logic [LEN_BITS-1:0]    frame_len_o,
    output logic [RESULT_BITS-1:0] result_o,
    output logic                   valid_o
);

    line_ctrl_t tx_ctrl;
    line_ctrl_t rx_ctrl;
    frame_t     built_frame;
    len_t       built_len;
    result_t    decoded;
    result_t    result_q;

    assign tx_ctrl = line_ctrl_t'(tx_lcr_i);
    assign rx_ctrl = line_ctrl_t'(rx_lcr_i);

    sfc_frame_builder u_builder (
        .data_i  (data_i),
        .ctrl_i  (tx_ctrl),
        .frame_o (built_frame),
        .len_o   (built_len)
    );

    sfc_frame_checker u_checker (
        .frame_i  (built_frame),
        .ctrl_i   (rx_ctrl),
        .result_o (decoded)
    );

    sfc_out_stage u_out (
        .clk      (clk),
        .rst      (rst),
        .load_i   (start_i),
        .frame_i  (built_frame),
        .len_i    (built_len),
        .result_i (decoded),
        .frame_o  (frame_o),
        .len_o    (frame_len_o),
        .result_o (result_q),
        .valid_o  (valid_o)
    );

    assign result_o = result_q;

endmodule

// File: rtl/serial_frame_codec_chk.sv
module serial_frame_codec_chk
    import sfc_pkg::*;
(
    input logic                   clk,
    input logic                   rst,
    input logic                   start_i,
    input logic [MAX_DATA_BITS-1:0] data_i,
    input logic [LCR_BITS-1:0]    tx_lcr_i,
    input logic [LCR_BITS-1:0]    rx_lcr_i,
    input logic [FRAME_BITS-1:0]  frame_o,
    input logic [LEN_BITS-1:0]    frame_len_o,
    input logic [RESULT_BITS-1:0] result_o,
    input logic                   valid_o
);

    // R10
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        start_i |=> valid_o);

    // R10
    valid_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !start_i |=> !valid_o);

    // R10
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !start_i |=> ($stable(result_o) && $stable(frame_o) && $stable(frame_len_o)));

    // R9
    rx_ctrl_copy_chk: assert property (@(posedge clk) disable iff (rst)
        start_i |=> result_o[15:8] == $past(rx_lcr_i));

    // R7
    no_parity_err_chk: assert property (@(posedge clk) disable iff (rst)
        (start_i && !rx_lcr_i[3]) |=> !result_o[16]);

    // R3
    len_range_chk: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> (frame_len_o >= 4'd6 && frame_len_o <= 4'd11));

    // R3
    last_bit_stop_chk: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> frame_o[frame_len_o - 4'd1]);

    // R6
    matched_clean_chk: assert property (@(posedge clk) disable iff (rst)
        (start_i && tx_lcr_i[5:0] == rx_lcr_i[5:0]) |=> (result_o[17:16] == 2'b00));

endmodule

bind serial_frame_codec serial_frame_codec_chk u_chk (.*);

// File: tb/serial_frame_codec_bench.sv
`timescale 1ns/1ps
module serial_frame_codec_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        start_i;
    logic [7:0]  data_i;
    logic [7:0]  tx_lcr_i;
    logic [7:0]  rx_lcr_i;
    logic [11:0] frame_o;
    logic [3:0]  frame_len_o;
    logic [17:0] result_o;
    logic        valid_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #2 clk = ~clk;

    serial_frame_codec u_serial_frame_codec (
        .clk(clk), .rst(rst), .start_i(start_i), .data_i(data_i),
        .tx_lcr_i(tx_lcr_i), .rx_lcr_i(rx_lcr_i), .frame_o(frame_o),
        .frame_len_o(frame_len_o), .result_o(result_o), .valid_o(valid_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Reference packing (R1, R2, R3)
    function automatic logic [11:0] ref_frame(input logic [7:0] d, input logic [7:0] c, output int len);
        logic [11:0] f;
        int n, pos;
        logic p;
        n = 5 + int'(c[1:0]);
        f = '0;
        p = 1'b0;
        for (int i = 0; i < n; i++) begin
            f[i] = d[i];
            p ^= d[i];
        end
        pos = n;
        if (c[3]) begin
            f[pos] = c[5] ? 1'b1 : (c[4] ? p : ~p);
            pos++;
        end
        f[pos] = 1'b1; pos++;
        if (c[2]) begin f[pos] = 1'b1; pos++; end
        len = pos;
        return f;
    endfunction

    // Reference decode (R4..R9)
    function automatic logic [17:0] ref_result(input logic [11:0] f, input logic [7:0] c);
        logic [7:0] d;
        int n, s;
        logic x, pe, fe;
        n = 5 + int'(c[1:0]);
        d = '0;
        x = 1'b0;
        for (int i = 0; i < n; i++) d[i] = f[i];
        for (int i = 0; i <= n; i++) x ^= f[i];
        if (!c[3]) pe = 1'b0;
        else if (c[5]) pe = ~f[n];
        else pe = c[4] ? x : ~x;
        s  = c[3] ? n + 1 : n;
        fe = ~f[s];
        if (c[2]) fe = fe | ~f[s+1];
        return {fe, pe, c, d};
    endfunction

    task automatic run(input logic [7:0] d, input logic [7:0] tc, input logic [7:0] rc);
        logic [11:0] ef;
        logic [17:0] er;
        logic [17:0] held;
        int el;
        string ptag;
        ef = ref_frame(d, tc, el);
        er = ref_result(ef, rc);
        @(negedge clk);
        data_i = d; tx_lcr_i = tc; rx_lcr_i = rc; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (!rc[3]) ptag = "R7 parity err";
        else if (rc[5]) ptag = "R5 stick parity err";
        else ptag = "R6 parity err";
        chk("R1/R2/R3 frame", 32'(frame_o), 32'(ef));
        chk("R3 length", 32'(frame_len_o), 32'(el));
        chk("R4 data", 32'(result_o[7:0]), 32'(er[7:0]));
        chk(ptag, 32'(result_o[16]), 32'(er[16]));
        chk("R8 framing err", 32'(result_o[17]), 32'(er[17]));
        chk("R9 rx ctrl field", 32'(result_o[15:8]), 32'(rc));
        chk("R10 valid pulse", 32'(valid_o), 32'd1);
        held = result_o;
        data_i = ~d; rx_lcr_i = ~rc;
        @(negedge clk);
        chk("R10 valid low", 32'(valid_o), 32'd0);
        chk("R10 hold", 32'(result_o), 32'(held));
    endtask

    initial begin
        logic [11:0] f_a;
        logic [3:0]  l_a;
        void'($urandom(32'h5eed_0427));
        rst = 1'b1; start_i = 1'b0; data_i = '0; tx_lcr_i = '0; rx_lcr_i = '0;
        repeat (3) @(negedge clk);
        chk("R10 reset valid", 32'(valid_o), 32'd0);
        chk("R10 reset result", 32'(result_o), 32'd0);
        chk("R10 reset frame", 32'(frame_o), 32'd0);
        rst = 1'b0;

        // Directed corners
        run(8'hFF, 8'h00, 8'h00);   // 5 bits, upper data masked (R1)
        run(8'hA5, 8'h1B, 8'h1B);   // 8 bits even parity matched
        run(8'hA5, 8'h0B, 8'h1B);   // odd sent, even expected (R6)
        run(8'h07, 8'h3B, 8'h0B);   // stick sent, odd expected
        run(8'h06, 8'h1B, 8'h3B);   // even sent gives 0, stick expects 1 (R5)
        run(8'h06, 8'h3B, 8'h3B);   // stick matched (R2)
        run(8'h5A, 8'h03, 8'h07);   // one stop sent, two expected (R8)
        run(8'h5A, 8'h07, 8'h03);   // two sent, one expected
        run(8'h3C, 8'h0F, 8'h03);   // parity sent, none expected (R7)
        run(8'h3C, 8'h03, 8'h0B);   // no parity sent, parity expected
        run(8'h81, 8'h00, 8'h03);   // 5-bit frame read as 8 bits

        // R11: top control bits ignored by the encoder
        run(8'h96, 8'hC9, 8'h09);
        f_a = frame_o; l_a = frame_len_o;
        run(8'h96, 8'h09, 8'h09);
        chk("R11 frame ignores top bits", 32'(frame_o), 32'(f_a));
        chk("R11 length ignores top bits", 32'(frame_len_o), 32'(l_a));

        // Random
        for (int k = 0; k < 400; k++) begin
            logic [7:0] d, tc, rc;
            d  = 8'($urandom);
            tc = 8'($urandom);
            rc = ($urandom % 2 == 0) ? {2'($urandom), tc[5:0]} : 8'($urandom);
            run(d, tc, rc);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R10 watchdog actual=timeout expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule